// File: doc/BRIEF.md
# Synchronous Dual-Port RAM with Burst Address Counters

This block is a shared word array with two fully independent ports. Each port has its own clock. Address, control and write data are captured on the rising edge of that clock, so either port can read or write any word while the other port does the same. The array depth is set by `ADDR_W`. The default is kept small so that elaboration stays quick; raise it to 16 for a 64K-word array.

Each port keeps its access address in a burst counter rather than taking it straight from the pins. On every edge the counter does one of four things, decoded in priority order:
- `CTR_CLEAR`: forced to zero.
- `CTR_LOAD`: loaded from the address input.
- `CTR_STEP`: advanced by one, wrapping from the last word to word 0.
- `CTR_HOLD`: kept as it is.

A mode input on each port chooses the read path. In flow-through mode the read data comes straight from the array in the cycle the address is captured. In pipelined mode the data passes through one extra register first.

A three-state output machine per port decides when the data pins may drive:
- `OUT_OFF`: nothing to drive.
- `OUT_FILL`: a pipelined read has been captured but its data is not out yet.
- `OUT_ON`: read data is valid.

Its transitions are:
- OFF→FILL: a pipelined read is captured.
- OFF→ON: a flow-through read is captured.
- FILL→ON: the pipeline register loads.
- ON→ON: another read follows.
- ON→FILL: a new pipelined read follows a non-read.
- ON→OFF and FILL→OFF: no read is captured.

The pad ring turns `*_drive` low into high impedance.

Top module: `dpr_sync_ram`

## Requirements
- R1: Both ports may access the array in the same cycle. A word written through one port reads back through the other, and both ports may read one word at once.
- R2: With `*_pipe`=0, read data and `*_drive`=1 appear right after the edge that captures the read, sampled in that same clock cycle.
- R3: With `*_pipe`=1, read data appears one clock cycle later than in R2.
- R4: `*_ld`=1 loads the burst counter from `*_addr` at the edge. The load beats `*_inc`.
- R5: `*_inc`=1 (without clear or load) advances the counter by one per edge. Successive words are written or read at successive addresses.
- R6: The counter wraps from address 2^ADDR_W-1 to 0.
- R7: `*_clr`=1 clears the counter to 0 and beats `*_ld` and `*_inc`. With none of the three asserted, the counter holds its value, including while the port is deselected.
- R8: A port is selected only when `*_cs_n`=0 and `*_cs`=1. When deselected, a write leaves the array unchanged and `*_drive` stays 0. After reset both drive outputs are 0.
- R9: In pipelined mode, after a deselect the port drives nothing in the first selected read cycle and drives from the next cycle on.
- R10: `*_drive` is 1 only for a selected read with `*_oe_n`=0. Write cycles never drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both ports |
| a_clk | input | 1 | Port A clock |
| a_cs_n | input | 1 | Port A active-low select |
| a_cs | input | 1 | Port A active-high select |
| a_rnw | input | 1 | Port A direction, 1 read, 0 write |
| a_oe_n | input | 1 | Port A active-low output gate, asynchronous |
| a_ld | input | 1 | Port A counter load from a_addr |
| a_inc | input | 1 | Port A counter increment |
| a_clr | input | 1 | Port A counter clear |
| a_pipe | input | 1 | Port A read mode, 1 pipelined, 0 flow-through |
| a_addr | input | ADDR_W | Port A address for counter load |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data |
| a_drive | output | 1 | Port A pad drive enable |
| b_clk | input | 1 | Port B clock |
| b_cs_n | input | 1 | Port B active-low select |
| b_cs | input | 1 | Port B active-high select |
| b_rnw | input | 1 | Port B direction, 1 read, 0 write |
| b_oe_n | input | 1 | Port B active-low output gate, asynchronous |
| b_ld | input | 1 | Port B counter load from b_addr |
| b_inc | input | 1 | Port B counter increment |
| b_clr | input | 1 | Port B counter clear |
| b_pipe | input | 1 | Port B read mode, 1 pipelined, 0 flow-through |
| b_addr | input | ADDR_W | Port B address for counter load |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data |
| b_drive | output | 1 | Port B pad drive enable |

## Verification
The key same-cycle case is a counter clear arriving in the same cycle as a load, or a load in the same cycle as an increment. The bench raises these inputs together on one edge and reads the addressed word in flow-through mode; the returned data shows which control won. A second case is both ports working in one cycle: one port writes a word while the other writes a different word, and then both read the same word together. The scoreboard predicts each result from the sequence of captured edges.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    // counter action chosen at each edge, highest priority first: clear, load, step
    typedef enum logic [1:0] {
        CTR_HOLD  = 2'd0,
        CTR_STEP  = 2'd1,
        CTR_LOAD  = 2'd2,
        CTR_CLEAR = 2'd3
    } ctr_op_e;

    // read output stage of one port
    typedef enum logic [1:0] {
        OUT_OFF  = 2'd0,
        OUT_FILL = 2'd1,
        OUT_ON   = 2'd2
    } out_st_e;

endpackage

// File: rtl/dpr_burst_ctr.sv
module dpr_burst_ctr
    import dpr_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          ld,
    input  logic          inc,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] cnt
);

    ctr_op_e op;

    always_comb begin
        if (clr)      op = CTR_CLEAR;
        else if (ld)  op = CTR_LOAD;
        else if (inc) op = CTR_STEP;
        else          op = CTR_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            unique case (op)
                CTR_CLEAR: cnt <= '0;
                CTR_LOAD:  cnt <= addr_in;
                CTR_STEP:  cnt <= cnt + 1'b1;
                CTR_HOLD:  cnt <= cnt;
                default:   cnt <= cnt;
            endcase
        end
    end

    AST_CTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0)); // R7
    AST_CTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && ld) |=> (cnt == $past(addr_in))); // R4
    AST_CTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ld && inc) |=> (cnt == AW'($past(cnt) + 1'b1))); // R6
    AST_CTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ld && !inc) |=> $stable(cnt)); // R7

endmodule

// File: rtl/dpr_xor_bank.sv
module dpr_xor_bank #(
    parameter int AW = 10,
    parameter int DW = 16
) (
    input  logic          a_clk,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    input  logic          b_clk,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata
);

    localparam int DEPTH = 1 << AW;

    // each half is written by one clock only; a word is the xor of both halves
    logic [DW-1:0] half_a [DEPTH];
    logic [DW-1:0] half_b [DEPTH];

    always_ff @(posedge a_clk) begin
        if (a_we) half_a[a_addr] <= a_wdata ^ half_b[a_addr];
    end

    always_ff @(posedge b_clk) begin
        if (b_we) half_b[b_addr] <= b_wdata ^ half_a[b_addr];
    end

    always_comb begin
        a_rdata = half_a[a_addr] ^ half_b[a_addr];
        b_rdata = half_a[b_addr] ^ half_b[b_addr];
    end

endmodule

// File: rtl/dpr_port.sv
module dpr_port
    import dpr_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          cs,
    input  logic          rnw,
    input  logic          oe_n,
    input  logic          ld,
    input  logic          inc,
    input  logic          clr,
    input  logic          pipe,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] acc_addr,
    output logic          wr_en,
    output logic [DW-1:0] wr_data,
    output logic [DW-1:0] rdata,
    output logic          drive
);

    logic          sel_in;
    logic          rd_in;
    logic          rd_now;
    logic          sel_q;
    logic          rnw_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] pipe_q;
    out_st_e       st;
    out_st_e       st_nx;

    assign sel_in = ~cs_n & cs;
    assign rd_in  = sel_in & rnw;
    assign rd_now = sel_q & rnw_q;

    dpr_burst_ctr #(.AW(AW)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .ld      (ld),
        .inc     (inc),
        .addr_in (addr),
        .cnt     (acc_addr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= 1'b0;
            rnw_q   <= 1'b1;
            wdata_q <= '0;
            pipe_q  <= '0;
        end else begin
            sel_q   <= sel_in;
            rnw_q   <= rnw;
            wdata_q <= wdata;
            if (rd_now) pipe_q <= mem_rdata;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= OUT_OFF;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = OUT_OFF;
        unique case (st)
            OUT_OFF: begin
                if (pipe) st_nx = rd_in ? OUT_FILL : OUT_OFF;
                else      st_nx = rd_in ? OUT_ON   : OUT_OFF;
            end
            OUT_FILL: begin
                if (pipe) st_nx = OUT_ON;
                else      st_nx = rd_in ? OUT_ON : OUT_OFF;
            end
            OUT_ON: begin
                if (pipe) st_nx = rd_now ? OUT_ON : (rd_in ? OUT_FILL : OUT_OFF);
                else      st_nx = rd_in ? OUT_ON : OUT_OFF;
            end
            default: st_nx = OUT_OFF;
        endcase
    end

    // outputs
    always_comb begin
        drive   = (st == OUT_ON) && !oe_n;
        rdata   = pipe ? pipe_q : mem_rdata;
        wr_en   = sel_q & ~rnw_q;
        wr_data = wdata_q;
    end

    AST_FLOW_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe && rd_in) |=> (st == OUT_ON)); // R2
    AST_PIPE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe && st == OUT_OFF) |=> (st != OUT_ON)); // R9
    AST_DESEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_in |=> !wr_en); // R8
    AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe && st == OUT_ON) |-> !wr_en); // R10

endmodule

// File: rtl/dpr_sync_ram.sv
module dpr_sync_ram #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              rst_n,
    input  logic              a_clk,
    input  logic              a_cs_n,
    input  logic              a_cs,
    input  logic              a_rnw,
    input  logic              a_oe_n,
    input  logic              a_ld,
    input  logic              a_inc,
    input  logic              a_clr,
    input  logic              a_pipe,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_drive,
    input  logic              b_clk,
    input  logic              b_cs_n,
    input  logic              b_cs,
    input  logic              b_rnw,
    input  logic              b_oe_n,
    input  logic              b_ld,
    input  logic              b_inc,
    input  logic              b_clr,
    input  logic              b_pipe,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_drive
);

    logic [ADDR_W-1:0] a_acc, b_acc;
    logic              a_we, b_we;
    logic [DATA_W-1:0] a_wd, b_wd;
    logic [DATA_W-1:0] a_mem, b_mem;

    dpr_port #(.AW(ADDR_W), .DW(DATA_W)) u_port_a (
        .clk(a_clk), .rst_n(rst_n), .cs_n(a_cs_n), .cs(a_cs), .rnw(a_rnw),
        .oe_n(a_oe_n), .ld(a_ld), .inc(a_inc), .clr(a_clr), .pipe(a_pipe),
        .addr(a_addr), .wdata(a_wdata), .mem_rdata(a_mem), .acc_addr(a_acc),
        .wr_en(a_we), .wr_data(a_wd), .rdata(a_rdata), .drive(a_drive)
    );

    dpr_port #(.AW(ADDR_W), .DW(DATA_W)) u_port_b (
        .clk(b_clk), .rst_n(rst_n), .cs_n(b_cs_n), .cs(b_cs), .rnw(b_rnw),
        .oe_n(b_oe_n), .ld(b_ld), .inc(b_inc), .clr(b_clr), .pipe(b_pipe),
        .addr(b_addr), .wdata(b_wdata), .mem_rdata(b_mem), .acc_addr(b_acc),
        .wr_en(b_we), .wr_data(b_wd), .rdata(b_rdata), .drive(b_drive)
    );

    dpr_xor_bank #(.AW(ADDR_W), .DW(DATA_W)) u_bank (
        .a_clk(a_clk), .a_we(a_we), .a_addr(a_acc), .a_wdata(a_wd), .a_rdata(a_mem),
        .b_clk(b_clk), .b_we(b_we), .b_addr(b_acc), .b_wdata(b_wd), .b_rdata(b_mem)
    );

endmodule

// File: tb/test_dpr_sync_ram.sv
module test_dpr_sync_ram;

    localparam int AW = 6;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          a_cs_n, a_cs, a_rnw, a_oe_n, a_ld, a_inc, a_clr, a_pipe;
    logic [AW-1:0] a_addr;
    logic [DW-1:0] a_wdata, a_rdata;
    logic          a_drive;
    logic          b_cs_n, b_cs, b_rnw, b_oe_n, b_ld, b_inc, b_clr, b_pipe;
    logic [AW-1:0] b_addr;
    logic [DW-1:0] b_wdata, b_rdata;
    logic          b_drive;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct {
        int          at;
        bit          port;
        bit          drv;
        logic [DW-1:0] data;
        string       req;
    } exp_t;

    exp_t sbq[$];

    always #10 clk = ~clk;   // 50 MHz

    dpr_sync_ram #(.ADDR_W(AW), .DATA_W(DW)) i_dpr_sync_ram (
        .rst_n(rst_n),
        .a_clk(clk), .a_cs_n(a_cs_n), .a_cs(a_cs), .a_rnw(a_rnw), .a_oe_n(a_oe_n),
        .a_ld(a_ld), .a_inc(a_inc), .a_clr(a_clr), .a_pipe(a_pipe), .a_addr(a_addr),
        .a_wdata(a_wdata), .a_rdata(a_rdata), .a_drive(a_drive),
        .b_clk(clk), .b_cs_n(b_cs_n), .b_cs(b_cs), .b_rnw(b_rnw), .b_oe_n(b_oe_n),
        .b_ld(b_ld), .b_inc(b_inc), .b_clr(b_clr), .b_pipe(b_pipe), .b_addr(b_addr),
        .b_wdata(b_wdata), .b_rdata(b_rdata), .b_drive(b_drive)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare every item due at this sampling point
    always @(negedge clk) begin
        for (int i = sbq.size() - 1; i >= 0; i--) begin
            if (sbq[i].at <= cyc) begin
                logic          gd;
                logic [DW-1:0] gv;
                gd = sbq[i].port ? b_drive : a_drive;
                gv = sbq[i].port ? b_rdata : a_rdata;
                n_chk++;
                if (gd !== sbq[i].drv || (sbq[i].drv && gv !== sbq[i].data)) begin
                    n_bad++;
                    $display("FAIL %s port=%0d cyc=%0d actual drive=%0b data=%h expected drive=%0b data=%h",
                             sbq[i].req, sbq[i].port, cyc, gd, gv, sbq[i].drv, sbq[i].data);
                end
                sbq.delete(i);
            end
        end
    end

    task automatic nxt();
        @(negedge clk);
        #2;
    endtask

    task automatic push(input bit port, input int at, input bit drv,
                        input logic [DW-1:0] data, input string req);
        exp_t e;
        e.at = at; e.port = port; e.drv = drv; e.data = data; e.req = req;
        sbq.push_back(e);
    endtask

    task automatic set_a(input bit sel, input bit rnw, input bit oe_n, input bit ld,
                         input bit inc, input bit clr, input logic [AW-1:0] ad,
                         input logic [DW-1:0] wd);
        a_cs_n = !sel; a_cs = sel; a_rnw = rnw; a_oe_n = oe_n;
        a_ld = ld; a_inc = inc; a_clr = clr; a_addr = ad; a_wdata = wd;
    endtask

    task automatic set_b(input bit sel, input bit rnw, input bit oe_n, input bit ld,
                         input bit inc, input bit clr, input logic [AW-1:0] ad,
                         input logic [DW-1:0] wd);
        b_cs_n = !sel; b_cs = sel; b_rnw = rnw; b_oe_n = oe_n;
        b_ld = ld; b_inc = inc; b_clr = clr; b_addr = ad; b_wdata = wd;
    endtask

    task automatic idle_a(); set_a(0, 1, 0, 0, 0, 0, '0, '0); endtask
    task automatic idle_b(); set_b(0, 1, 0, 0, 0, 0, '0, '0); endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #3_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        a_pipe = 0; b_pipe = 0;
        idle_a(); idle_b();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        nxt();
        n_chk++;
        if (a_drive !== 1'b0 || b_drive !== 1'b0) begin
            n_bad++;
            $display("FAIL R8 reset actual a=%0b b=%0b expected 0 0", a_drive, b_drive);
        end

        // R1 R4 R5: A burst write 5..7 while B writes word 20; R10 writes silent
        nxt(); set_a(1, 0, 0, 1, 0, 0, 5, 16'h1111); set_b(1, 0, 0, 1, 0, 0, 20, 16'hBEEF);
        push(0, cyc + 1, 0, '0, "R10"); push(1, cyc + 1, 0, '0, "R10");
        nxt(); set_a(1, 0, 0, 0, 1, 0, 0, 16'h2222); idle_b();
        nxt(); set_a(1, 0, 0, 0, 1, 0, 0, 16'h3333);
        nxt(); idle_a();

        // R1 cross reads, flow-through R2
        nxt(); set_a(1, 1, 0, 1, 0, 0, 20, '0); set_b(1, 1, 0, 1, 0, 0, 5, '0);
        push(0, cyc + 1, 1, 16'hBEEF, "R1"); push(1, cyc + 1, 1, 16'h1111, "R2");
        nxt(); idle_a(); set_b(1, 1, 0, 1, 0, 0, 5, '0); push(1, cyc + 1, 1, 16'h1111, "R5");
        nxt(); set_b(1, 1, 0, 0, 1, 0, 0, '0); push(1, cyc + 1, 1, 16'h2222, "R5");
        nxt(); set_b(1, 1, 0, 0, 1, 0, 0, '0); push(1, cyc + 1, 1, 16'h3333, "R5");
        nxt(); idle_b(); a_pipe = 1;

        // pipelined: R9 wake cycle, R3 latency
        nxt(); set_a(1, 1, 0, 1, 0, 0, 6, '0);
        push(0, cyc + 1, 0, '0, "R9"); push(0, cyc + 2, 1, 16'h2222, "R3");
        nxt(); set_a(1, 1, 0, 0, 1, 0, 0, '0); push(0, cyc + 2, 1, 16'h3333, "R3");
        nxt(); idle_a(); push(0, cyc + 2, 0, '0, "R8");
        nxt();
        nxt(); a_pipe = 0;

        // R6 wrap
        nxt(); set_a(1, 0, 0, 1, 0, 0, 63, 16'hAAAA);
        nxt(); set_a(1, 0, 0, 0, 1, 0, 0, 16'h5555);
        nxt(); idle_a();
        nxt(); set_b(1, 1, 0, 1, 0, 0, 0, '0); push(1, cyc + 1, 1, 16'h5555, "R6");
        // R7 hold: A counter stayed at 0 while deselected
        set_a(1, 1, 0, 0, 0, 0, 40, '0); push(0, cyc + 1, 1, 16'h5555, "R7");
        nxt(); set_b(1, 1, 0, 1, 0, 0, 63, '0); push(1, cyc + 1, 1, 16'hAAAA, "R6");
        set_a(1, 1, 0, 1, 0, 1, 63, '0); push(0, cyc + 1, 1, 16'h5555, "R7");
        nxt(); idle_b(); set_a(1, 1, 0, 1, 1, 0, 5, '0); push(0, cyc + 1, 1, 16'h1111, "R4");
        nxt(); idle_a();

        // R8 deselect by either select pin: no write, no drive
        nxt(); a_cs_n = 0; a_cs = 0; a_rnw = 0; a_ld = 1; a_addr = 6; a_wdata = 16'hDEAD;
        push(0, cyc + 1, 0, '0, "R8");
        nxt(); a_cs_n = 1; a_cs = 1; a_rnw = 1; a_ld = 1; a_addr = 7;
        push(0, cyc + 1, 0, '0, "R8");
        nxt(); idle_a();
        nxt(); set_b(1, 1, 0, 1, 0, 0, 6, '0); push(1, cyc + 1, 1, 16'h2222, "R8");
        set_a(1, 1, 0, 1, 0, 0, 7, '0); push(0, cyc + 1, 1, 16'h3333, "R8");

        // R10 output gate
        nxt(); idle_a(); set_b(1, 1, 1, 1, 0, 0, 5, '0); push(1, cyc + 1, 0, '0, "R10");
        nxt(); set_b(1, 1, 0, 0, 0, 0, 0, '0); push(1, cyc + 1, 1, 16'h1111, "R10");
        nxt(); set_b(1, 0, 0, 1, 0, 0, 30, 16'h0F0F); push(1, cyc + 1, 0, '0, "R10");
        nxt(); idle_b();

        // R1: written by B, both ports read the same word together
        nxt(); set_a(1, 1, 0, 1, 0, 0, 30, '0); set_b(1, 1, 0, 1, 0, 0, 30, '0);
        push(0, cyc + 1, 1, 16'h0F0F, "R1"); push(1, cyc + 1, 1, 16'h0F0F, "R1");
        nxt(); idle_a(); idle_b();
        repeat (4) nxt();
        if (sbq.size() != 0) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 pending actual=%0d expected=0", sbq.size());
        end
        finish_run();
    end

endmodule